// File: doc/BRIEF.md
# Double-Buffered Frame Receive Store

This block sits between a serial frame receiver and a host processor. It holds two message stores that take turns. One store fills with the frame now arriving on the line. The other store holds the last finished message, which the host drains one byte at a time. The host only ever sees one store. When a frame ends cleanly, its store is offered to the host, unless the host is still busy with an earlier message. In that case the new message waits and is offered as soon as the earlier one has been read or discarded.

The receiver marks each frame with a start strobe. It then sends data bytes with a valid strobe and a flag for response bytes sent inside the frame, and closes the frame with either a good-end strobe or an abort strobe (CRC failure or a line error). The block only stores bytes; it does not care who sent a frame, so frames this node sent itself are stored like any other. While both stores hold unread messages, every frame that starts is refused in whole. The host side uses a request-to-send line, a one-byte-per-pulse clear-to-send handshake and a flush input.

Top module: `rxpp_store`

## Requirements
- R1: After reset, host_rts and host_data_vld are low, and both stores are empty.
- R2: One cycle after a good end (rx_eof_ok) of a frame with at least one stored byte, host_rts is high. Each cycle in which host_cts is high while host_rts is high (and host_flush is low) yields one byte on host_data, with host_data_vld high in the next cycle. Bytes come out in arrival order, and host_last is high with the final byte only.
- R3: host_rts falls in the cycle after the final byte is taken or after a flush, provided no other finished message is waiting. It never falls for any other reason.
- R4: Two finished messages can be held at the same time. They are presented in the order they finished.
- R5: A frame whose start strobe comes while both stores hold unread messages is dropped in whole. This holds even if a store is freed before that frame ends.
- R6: While the host reads one message, a new frame fills the other store. The message being read is not altered by it.
- R7: A byte delivered with rx_ifr high is neither stored nor counted toward the message length.
- R8: A frame ended by rx_abort, or a good end with zero stored bytes, frees its store without offering it to the host. The message the host currently sees is left unchanged.
- R9: A message of up to DEPTH (11) bytes is kept whole. A frame that delivers a further data byte beyond DEPTH is discarded at its end.
- R10: A high host_flush while host_rts is high discards the visible message and presents the next waiting one. When host_flush and host_cts are both high in the same cycle, the flush wins and no byte is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_sof | input | 1 | Frame start strobe |
| rx_byte_vld | input | 1 | A received byte is on rx_byte |
| rx_ifr | input | 1 | Marks the current byte as in-frame response data |
| rx_byte | input | 8 | Received byte |
| rx_eof_ok | input | 1 | Frame ended cleanly with a good CRC |
| rx_abort | input | 1 | Frame ended in error |
| host_flush | input | 1 | Discard the message visible to the host |
| host_cts | input | 1 | Host takes one byte |
| host_rts | output | 1 | A finished message is available |
| host_data | output | 8 | Byte delivered to the host |
| host_data_vld | output | 1 | host_data is valid this cycle |
| host_last | output | 1 | The delivered byte is the last of its message |

## Verification
Errors in this block show up quickly at the host side. If a full flag is wrong, host_rts stays high after the last byte, or a message appears that should have been refused. Both show on the cycle after the read or frame end. If the visible-store pointer is wrong, the bytes from the other store come out in place of the expected message on the very first byte read. An off-by-one in the length or fill count moves host_last, or lets a twelfth byte through; this shows at the last byte of the affected message. The directed scenarios read back every message in full so that each of these faults shows up as a byte or flag mismatch.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
  // true when a read pointer addresses the final stored byte
  function automatic logic ptr_is_last(input int unsigned ptr, input int unsigned len);
    return (ptr + 1) == len;
  endfunction

  // true when a fill count has reached the store capacity
  function automatic logic at_cap(input int unsigned cnt, input int unsigned depth);
    return cnt >= depth;
  endfunction
endpackage

// File: rtl/rxpp_bank.sv
module rxpp_bank #(
  parameter int unsigned DEPTH = 11,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 4,
  parameter int unsigned LW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          len_we,
  input  logic [LW-1:0] len_in,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] len_out
);
  localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [LW-1:0] len_q;

  always_ff @(posedge clk) begin
    if (we && waddr <= LAST_A) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      len_q <= '0;
    else if (len_we) len_q <= len_in;
  end

  assign rdata   = mem[raddr];
  assign len_out = len_q;
endmodule

// File: rtl/rxpp_fill.sv
module rxpp_fill #(
  parameter int unsigned DEPTH = 11,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 4,
  parameter int unsigned LW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_sof,
  input  logic          rx_byte_vld,
  input  logic          rx_ifr,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_eof_ok,
  input  logic          rx_abort,
  input  logic [1:0]    full,
  input  logic          vis,
  output logic          wr_en,
  output logic          wr_bank,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          commit,
  output logic [LW-1:0] commit_len
);
  import rxpp_pkg::*;

  logic          active;
  logic          tgt;
  logic          ovr;
  logic [LW-1:0] cnt;
  logic          data_byte;
  logic          cap_hit;

  assign data_byte  = rx_byte_vld && !rx_ifr;
  assign cap_hit    = at_cap(32'(cnt), DEPTH);
  assign wr_en      = active && data_byte && !ovr && !cap_hit;
  assign wr_bank    = tgt;
  assign wr_addr    = AW'(cnt);
  assign wr_data    = rx_byte;
  assign commit     = active && rx_eof_ok && !ovr && (cnt != '0);
  assign commit_len = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      tgt    <= 1'b0;
      ovr    <= 1'b0;
      cnt    <= '0;
    end else if (rx_sof) begin
      // the store opposite the visible one takes the frame, if it is free
      active <= !full[~vis];
      tgt    <= ~vis;
      ovr    <= 1'b0;
      cnt    <= '0;
    end else if (active) begin
      if (rx_eof_ok || rx_abort) active <= 1'b0;
      else if (data_byte) begin
        if (cap_hit) ovr <= 1'b1;
        else         cnt <= cnt + LW'(1);
      end
    end
  end
endmodule

// File: rtl/rxpp_drain.sv
module rxpp_drain #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4,
  parameter int unsigned LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic          commit_bank,
  input  logic          flush,
  input  logic          cts,
  input  logic [LW-1:0] len_vis,
  input  logic [DW-1:0] rdata_vis,
  output logic [1:0]    full,
  output logic          vis,
  output logic [AW-1:0] rd_addr,
  output logic          rts,
  output logic [DW-1:0] data,
  output logic          data_vld,
  output logic          last,
  output logic          rel_now
);
  import rxpp_pkg::*;

  logic          take;
  logic          last_now;
  logic [LW-1:0] rd_ptr;

  assign rts      = full[vis];
  assign take     = rts && cts && !flush;
  assign last_now = ptr_is_last(32'(rd_ptr), 32'(len_vis));
  assign rel_now  = (rts && flush) || (take && last_now);
  assign rd_addr  = AW'(rd_ptr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full     <= '0;
      vis      <= 1'b0;
      rd_ptr   <= '0;
      data     <= '0;
      data_vld <= 1'b0;
      last     <= 1'b0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (commit && commit_bank == 1'(b))  full[b] <= 1'b1;
        else if (rel_now && vis == 1'(b))    full[b] <= 1'b0;
      end
      if (rel_now)                  vis <= ~vis;
      else if (commit && !full[vis]) vis <= commit_bank;
      if (rel_now)   rd_ptr <= '0;
      else if (take) rd_ptr <= rd_ptr + LW'(1);
      data_vld <= take;
      if (take) begin
        data <= rdata_vis;
        last <= last_now;
      end
    end
  end
endmodule

// File: rtl/rxpp_store.sv
module rxpp_store #(
  parameter int unsigned DEPTH = 11,
  parameter int unsigned DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_sof,
  input  logic          rx_byte_vld,
  input  logic          rx_ifr,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_eof_ok,
  input  logic          rx_abort,
  input  logic          host_flush,
  input  logic          host_cts,
  output logic          host_rts,
  output logic [DW-1:0] host_data,
  output logic          host_data_vld,
  output logic          host_last
);
  localparam int unsigned ADDR_W = (DEPTH < 2) ? 1 : $clog2(DEPTH);
  localparam int unsigned LEN_W  = $clog2(DEPTH + 1);

  logic              wr_en;
  logic              wr_bank;
  logic [ADDR_W-1:0] wr_addr;
  logic [DW-1:0]     wr_data;
  logic              commit;
  logic [LEN_W-1:0]  commit_len;
  logic [1:0]        full;
  logic              vis;
  logic              rel_now;
  logic [ADDR_W-1:0] rd_addr;
  logic [DW-1:0]     bank_rd  [2];
  logic [LEN_W-1:0]  bank_len [2];

  rxpp_fill #(.DEPTH(DEPTH), .DW(DW), .AW(ADDR_W), .LW(LEN_W)) u_fill (
    .clk, .rst_n, .rx_sof, .rx_byte_vld, .rx_ifr, .rx_byte, .rx_eof_ok, .rx_abort,
    .full, .vis, .wr_en, .wr_bank, .wr_addr, .wr_data, .commit, .commit_len
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    rxpp_bank #(.DEPTH(DEPTH), .DW(DW), .AW(ADDR_W), .LW(LEN_W)) u_bank (
      .clk, .rst_n,
      .we      (wr_en && wr_bank == 1'(b)),
      .waddr   (wr_addr),
      .wdata   (wr_data),
      .len_we  (commit && wr_bank == 1'(b)),
      .len_in  (commit_len),
      .raddr   (rd_addr),
      .rdata   (bank_rd[b]),
      .len_out (bank_len[b])
    );
  end

  rxpp_drain #(.DW(DW), .AW(ADDR_W), .LW(LEN_W)) u_drain (
    .clk, .rst_n, .commit, .commit_bank(wr_bank), .flush(host_flush), .cts(host_cts),
    .len_vis(bank_len[vis]), .rdata_vis(bank_rd[vis]),
    .full, .vis, .rd_addr, .rts(host_rts), .data(host_data),
    .data_vld(host_data_vld), .last(host_last), .rel_now
  );
endmodule

// File: rtl/rxpp_store_chk.sv
module rxpp_store_chk #(
  parameter int unsigned DEPTH = 11,
  parameter int unsigned AW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_byte_vld,
  input logic          rx_ifr,
  input logic          rx_abort,
  input logic          host_flush,
  input logic          host_cts,
  input logic          host_rts,
  input logic          host_data_vld,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          commit
);
  localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);

  // R2
  vld_after_cts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_data_vld |-> $past(host_cts && host_rts && !host_flush));

  // R2
  commit_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> host_rts);

  // R3
  rts_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_rts) |-> $past(host_flush || host_cts));

  // R7
  ifr_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_byte_vld && rx_ifr) |-> !wr_en);

  // R8
  abort_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_abort && host_rts && !host_cts && !host_flush) |=> host_rts);

  // R9
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr <= LAST_A));

  // R10
  flush_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_flush && host_rts) |=> !host_data_vld);
endmodule

bind rxpp_store rxpp_store_chk #(.DEPTH(DEPTH), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_byte_vld(rx_byte_vld), .rx_ifr(rx_ifr),
  .rx_abort(rx_abort), .host_flush(host_flush), .host_cts(host_cts),
  .host_rts(host_rts), .host_data_vld(host_data_vld), .wr_en(wr_en),
  .wr_addr(wr_addr), .commit(commit)
);

// File: tb/sim_rxpp_store.sv
`timescale 1ns/1ps
module sim_rxpp_store;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_sof = 0, rx_byte_vld = 0, rx_ifr = 0, rx_eof_ok = 0, rx_abort = 0;
  logic [7:0] rx_byte = '0;
  logic host_flush = 0, host_cts = 0;
  logic host_rts, host_data_vld, host_last;
  logic [7:0] host_data;

  int n_total = 0;
  int n_fail  = 0;
  logic [7:0] exp_b [16];
  int exp_n;

  always #10 clk = ~clk;

  rxpp_store u0 (
    .clk, .rst_n, .rx_sof, .rx_byte_vld, .rx_ifr, .rx_byte, .rx_eof_ok, .rx_abort,
    .host_flush, .host_cts, .host_rts, .host_data, .host_data_vld, .host_last
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed * 16 + i);
  endfunction

  // expected stored bytes: frame bytes with response-marked ones removed
  task automatic load_exp(input int seed, input int n, input logic [15:0] ifr);
    exp_n = 0;
    for (int i = 0; i < n; i++) if (!ifr[i]) begin
      exp_b[exp_n] = pat(seed, i);
      exp_n++;
    end
  endtask

  task automatic frame_start();
    @(negedge clk) rx_sof = 1;
    @(negedge clk) rx_sof = 0;
  endtask

  task automatic frame_body(input int seed, input int n, input logic [15:0] ifr, input bit abort);
    for (int i = 0; i < n; i++) begin
      rx_byte_vld = 1; rx_byte = pat(seed, i); rx_ifr = ifr[i];
      @(negedge clk);
    end
    rx_byte_vld = 0; rx_ifr = 0;
    if (abort) rx_abort = 1; else rx_eof_ok = 1;
    @(negedge clk) begin rx_abort = 0; rx_eof_ok = 0; end
  endtask

  task automatic send(input int seed, input int n, input logic [15:0] ifr, input bit abort);
    frame_start();
    frame_body(seed, n, ifr, abort);
  endtask

  // reads exp_b[from..exp_n-1]; checks host_rts level after the last byte
  task automatic read_check(input string req, input int from, input bit rts_after);
    for (int i = from; i < exp_n; i++) begin
      check(host_rts == 1, req, int'(host_rts), 1);
      host_cts = 1;
      @(negedge clk) host_cts = 0;
      check(host_data_vld == 1 && host_data == exp_b[i], req, int'(host_data), int'(exp_b[i]));
      check(host_last == (i == exp_n - 1), {req, " last"}, int'(host_last), int'(i == exp_n - 1));
    end
    check(host_rts == rts_after, {req, " rts after"}, int'(host_rts), int'(rts_after));
  endtask

  task automatic t_reset();
    check(host_rts == 0, "R1 rts", int'(host_rts), 0);
    check(host_data_vld == 0, "R1 vld", int'(host_data_vld), 0);
  endtask

  task automatic t_single();
    send(1, 3, '0, 0);
    check(host_rts == 1, "R2 rts up", int'(host_rts), 1);
    load_exp(1, 3, '0);
    read_check("R2/R3 single", 0, 0);
  endtask

  task automatic t_pingpong();
    send(2, 4, '0, 0);
    send(3, 2, '0, 0);
    send(4, 5, '0, 0);                 // refused: both stores hold messages (R5)
    load_exp(2, 4, '0);
    read_check("R4 first", 0, 1);
    load_exp(3, 2, '0);
    read_check("R4/R5 second", 0, 0);
  endtask

  task automatic t_drop_midframe();
    send(5, 2, '0, 0);
    send(6, 3, '0, 0);
    frame_start();                     // starts while both full
    host_flush = 1;
    @(negedge clk) host_flush = 0;     // frees a store mid-frame
    frame_body(7, 4, '0, 0);
    load_exp(6, 3, '0);
    read_check("R5 midframe", 0, 0);
  endtask

  task automatic t_overlap();
    send(8, 3, '0, 0);
    load_exp(8, 3, '0);
    check(host_rts == 1, "R6 rts", int'(host_rts), 1);
    host_cts = 1;
    @(negedge clk) host_cts = 0;
    check(host_data_vld == 1 && host_data == exp_b[0], "R6 first byte", int'(host_data), int'(exp_b[0]));
    send(9, 4, '0, 0);
    read_check("R6 rest", 1, 1);
    load_exp(9, 4, '0);
    read_check("R6 next", 0, 0);
  endtask

  task automatic t_ifr();
    send(10, 5, 16'b01010, 0);
    load_exp(10, 5, 16'b01010);
    read_check("R7 ifr", 0, 0);
  endtask

  task automatic t_abort();
    send(11, 2, '0, 0);
    send(12, 3, '0, 1);
    check(host_rts == 1, "R8 rts kept", int'(host_rts), 1);
    send(13, 0, '0, 0);                // zero-length
    load_exp(11, 2, '0);
    read_check("R8 abort", 0, 0);
    send(14, 2, '0, 1);
    check(host_rts == 0, "R8 alone abort", int'(host_rts), 0);
  endtask

  task automatic t_overrun();
    send(1, 11, '0, 0);
    load_exp(1, 11, '0);
    read_check("R9 full length", 0, 0);
    send(2, 12, '0, 0);
    check(host_rts == 0, "R9 overrun dropped", int'(host_rts), 0);
  endtask

  task automatic t_flush();
    send(3, 2, '0, 0);
    send(4, 3, '0, 0);
    host_flush = 1; host_cts = 1;
    @(negedge clk) begin host_flush = 0; host_cts = 0; end
    check(host_data_vld == 0, "R10 no byte", int'(host_data_vld), 0);
    load_exp(4, 3, '0);
    read_check("R10 next shown", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_single();
    t_pingpong();
    t_drop_midframe();
    t_overlap();
    t_ifr();
    t_abort();
    t_overrun();
    t_flush();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule